// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Per-Port Read Latency

This block is a true dual-port synchronous memory. Ports A and B each have their own clock, reset, address, read/write select, a pair of chip enables with opposite polarity, active-low per-lane enables, write data, an output enable and a static latency-mode input. A word is split into byte lanes of `LANE_W` bits. Every control, address and data input is captured on the rising edge of its port's clock. The one exception is the output enable, which gates the outputs combinationally. The block models output drive as a per-lane enable vector (`*_lane_oe`) instead of tri-state pins. A lane whose enable is low reads as zero on the data output.

Each port chooses its read latency with its mode input. With the mode low (flow-through), read data appears after the same edge that captured the read. With the mode high (pipelined), read data appears one edge later. The port's address can come directly from the pins, or it can be held: while the address strobe is low, the pin address is loaded on every edge. While the strobe is high, the last loaded address is reused.

A shared sleep request puts both ports to sleep after a fixed number of edges and wakes them after another fixed count. While asleep, a port ignores all of its inputs and drives no lanes, and the memory keeps its contents.

Top module: `dpram_dual_latsel`

## Requirements
- R1: In flow-through mode (mode input 0), a read captured on rising edge k drives its data and lane enables from edge k until the next edge. Before edge k the port still shows its previous state.
- R2: In pipelined mode (mode input 1), a read captured on edge k appears only after edge k+1. Between edge k and edge k+1 the port still shows its previous state.
- R3: The read/write select means read when 1 and write when 0. A write updates only the lanes whose active-low lane enable is 0. Lane i covers data bits [LANE_W*i+LANE_W-1 : LANE_W*i].
- R4: A port is selected only when its chip enable 0 is low and its chip enable 1 is high. A deselected port performs no write. Its lane enables drop to 0 after the next rising edge, not before.
- R5: During a read, a lane enable held at 1 turns off only that lane of the result: its lane_oe bit is 0 and its data bits read 0. All other lanes show the stored data.
- R6: Output enable (active low) gates all lane enables without waiting for a clock. Raising it clears them at once, and lowering it restores them at once.
- R7: While the address strobe is low, the pin address is loaded on each edge. While it is high, the port uses the last loaded address and ignores the address pins.
- R8: If both ports write the same lane of the same address on the same edge, port B's data is kept. A read on one port in the same edge as a write from the other port to the same address returns the old contents.
- R9: A sleep request sampled high on two consecutive edges makes the ports sleep after the second of those edges. While asleep, a port ignores its inputs, drives no lanes, and loses no memory contents.
- R10: A sleep request sampled low on three consecutive edges ends sleep after the third of those edges. The first edge that executes commands again is the next one.
- R11: After reset, both ports drive no lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A asynchronous reset, active low |
| a_ce0_n | input | 1 | Port A chip enable, active low |
| a_ce1 | input | 1 | Port A chip enable, active high |
| a_rw | input | 1 | Port A select: 1 read, 0 write |
| a_ads_n | input | 1 | Port A address strobe, active low |
| a_be_n | input | LANES | Port A lane enables, active low |
| a_addr | input | ADDR_W | Port A address |
| a_wdata | input | LANES*LANE_W | Port A write data |
| a_oe_n | input | 1 | Port A output enable, active low, combinational |
| a_pipe | input | 1 | Port A latency mode: 0 flow-through, 1 pipelined |
| a_rdata | output | LANES*LANE_W | Port A read data, zero in lanes that are not driven |
| a_lane_oe | output | LANES | Port A per-lane drive enable |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B asynchronous reset, active low |
| b_ce0_n | input | 1 | Port B chip enable, active low |
| b_ce1 | input | 1 | Port B chip enable, active high |
| b_rw | input | 1 | Port B select: 1 read, 0 write |
| b_ads_n | input | 1 | Port B address strobe, active low |
| b_be_n | input | LANES | Port B lane enables, active low |
| b_addr | input | ADDR_W | Port B address |
| b_wdata | input | LANES*LANE_W | Port B write data |
| b_oe_n | input | 1 | Port B output enable, active low, combinational |
| b_pipe | input | 1 | Port B latency mode: 0 flow-through, 1 pipelined |
| b_rdata | output | LANES*LANE_W | Port B read data, zero in lanes that are not driven |
| b_lane_oe | output | LANES | Port B per-lane drive enable |
| sleep_req | input | 1 | Sleep request shared by both ports |

## Verification
The bench samples each port on both sides of the edge that should change it:
- Latency: it probes flow-through and pipelined reads before and after that edge. A design with an extra or missing register would show data one edge early or late.
- Deselect and output enable: a deselect that takes effect combinationally would blank the outputs before the edge. An output enable that is registered would lag by a cycle.
- Collisions: same-address writes on both ports must leave port B's data, and a read beside a write must return the old word. A mixed or forwarded result would expose a faulty collision path.
- Sleep: it counts two edges in and three edges out while a read is held steady, and it tries a write during sleep. A wrong count, a leaked write or lost contents would each show up as a mismatch.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
   localparam int unsigned SLEEP_ENTER_EDGES = 2;
   localparam int unsigned SLEEP_EXIT_EDGES  = 3;
   localparam int unsigned SLEEP_CNT_W       = 2;

   typedef enum logic {
      LAT_FLOW = 1'b0,
      LAT_PIPE = 1'b1
   } lat_mode_e;
endpackage

// File: rtl/dpram_sleep_seq.sv
module dpram_sleep_seq
   import dpram_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_req,
   output logic asleep
);
   logic [SLEEP_CNT_W-1:0] run;
   logic [SLEEP_CNT_W-1:0] limit;

   assign limit = asleep ? SLEEP_CNT_W'(SLEEP_EXIT_EDGES - 1)
                         : SLEEP_CNT_W'(SLEEP_ENTER_EDGES - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         asleep <= 1'b0;
         run    <= '0;
      end else if (sleep_req != asleep) begin
         if (run == limit) begin
            asleep <= ~asleep;
            run    <= '0;
         end else begin
            run <= run + 1'b1;
         end
      end else begin
         run <= '0;
      end
   end

   AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(asleep) |-> ($past(sleep_req, 1) && $past(sleep_req, 2))); // R9
   AST_SLEEP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(asleep) |-> (!$past(sleep_req, 1) && !$past(sleep_req, 2) && !$past(sleep_req, 3))); // R10
endmodule

// File: rtl/dpram_port_ctl.sv
module dpram_port_ctl #(
   parameter int unsigned ADDR_W = 9,
   parameter int unsigned LANES  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce0_n,
   input  logic              ce1,
   input  logic              rw,
   input  logic              ads_n,
   input  logic [LANES-1:0]  be_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              asleep,
   output logic [ADDR_W-1:0] eff_addr,
   output logic [LANES-1:0]  we_lanes,
   output logic              rd_fire,
   output logic [LANES-1:0]  rd_lanes
);
   logic [ADDR_W-1:0] addr_hold;
   logic              selected;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                addr_hold <= '0;
      else if (!asleep && !ads_n) addr_hold <= addr;
   end

   assign eff_addr = ads_n ? addr_hold : addr;
   assign selected = !ce0_n && ce1 && !asleep;
   assign we_lanes = (selected && !rw) ? ~be_n : '0;
   assign rd_fire  = selected && rw;
   assign rd_lanes = ~be_n;

   AST_DESEL_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (ce0_n || !ce1) |-> (we_lanes == '0 && !rd_fire)); // R4
   AST_ASLEEP_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      asleep |-> (we_lanes == '0 && !rd_fire)); // R9
endmodule

// File: rtl/dpram_xor_store.sv
module dpram_xor_store #(
   parameter int unsigned ADDR_W = 9,
   parameter int unsigned LANES  = 8,
   parameter int unsigned LANE_W = 9
) (
   input  logic                    clk_a,
   input  logic [ADDR_W-1:0]       a_addr,
   input  logic [LANES-1:0]        a_we,
   input  logic [LANES*LANE_W-1:0] a_wdata,
   input  logic                    a_re,
   output logic [LANES*LANE_W-1:0] a_rword,
   input  logic                    clk_b,
   input  logic [ADDR_W-1:0]       b_addr,
   input  logic [LANES-1:0]        b_we,
   input  logic [LANES*LANE_W-1:0] b_wdata,
   input  logic                    b_re,
   output logic [LANES*LANE_W-1:0] b_rword
);
   localparam int unsigned DEPTH  = 1 << ADDR_W;
   localparam int unsigned DATA_W = LANES * LANE_W;

   // Each port owns one bank; a word is the XOR of both banks.
   logic [DATA_W-1:0] bank_a [DEPTH];
   logic [DATA_W-1:0] bank_b [DEPTH];
   logic [LANES-1:0]  a_keep;

   // Port A yields any lane that port B writes at the same address.
   assign a_keep = a_we & ~(b_we & {LANES{a_addr == b_addr}});

   always_ff @(posedge clk_a) begin
      for (int l = 0; l < LANES; l++) begin
         if (a_keep[l])
            bank_a[a_addr][l*LANE_W +: LANE_W] <=
               a_wdata[l*LANE_W +: LANE_W] ^ bank_b[a_addr][l*LANE_W +: LANE_W];
      end
      if (a_re) a_rword <= bank_a[a_addr] ^ bank_b[a_addr];
   end

   always_ff @(posedge clk_b) begin
      for (int l = 0; l < LANES; l++) begin
         if (b_we[l])
            bank_b[b_addr][l*LANE_W +: LANE_W] <=
               b_wdata[l*LANE_W +: LANE_W] ^ bank_a[b_addr][l*LANE_W +: LANE_W];
      end
      if (b_re) b_rword <= bank_a[b_addr] ^ bank_b[b_addr];
   end
endmodule

// File: rtl/dpram_out_stage.sv
module dpram_out_stage
   import dpram_pkg::*;
#(
   parameter int unsigned LANES   = 8,
   parameter int unsigned LANE_W  = 9,
   parameter bit          PIPE_EN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    pipe_mode,
   input  logic                    rd_fire,
   input  logic [LANES-1:0]        rd_lanes,
   input  logic [LANES*LANE_W-1:0] rd_word,
   input  logic                    asleep,
   input  logic                    oe_n,
   output logic [LANES*LANE_W-1:0] dout,
   output logic [LANES-1:0]        dout_en
);
   localparam int unsigned DATA_W = LANES * LANE_W;

   logic [LANES-1:0]  s1_en;
   logic [LANES-1:0]  sel_en;
   logic [DATA_W-1:0] sel_word;
   logic              drive_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s1_en <= '0;
      else        s1_en <= rd_fire ? rd_lanes : '0;
   end

   generate
      if (PIPE_EN) begin : g_pipe
         logic [LANES-1:0]  s2_en;
         logic [DATA_W-1:0] s2_word;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s2_en   <= '0;
               s2_word <= '0;
            end else begin
               s2_en   <= s1_en;
               s2_word <= rd_word;
            end
         end
         assign sel_en   = (lat_mode_e'(pipe_mode) == LAT_PIPE) ? s2_en   : s1_en;
         assign sel_word = (lat_mode_e'(pipe_mode) == LAT_PIPE) ? s2_word : rd_word;

         AST_PIPE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n, 1) && $past(rst_n, 2) && pipe_mode && !oe_n && !asleep && $past(rd_fire, 2))
            |-> (dout_en == $past(rd_lanes, 2))); // R2
      end else begin : g_flow_only
         assign sel_en   = s1_en;
         assign sel_word = rd_word;
      end
   endgenerate

   assign drive_on = !oe_n && !asleep;
   assign dout_en  = sel_en & {LANES{drive_on}};

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         assign dout[l*LANE_W +: LANE_W] = dout_en[l] ? sel_word[l*LANE_W +: LANE_W] : '0;
      end
   endgenerate

   AST_FLOW_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !pipe_mode && !oe_n && !asleep && $past(rd_fire))
      |-> (dout_en == $past(rd_lanes))); // R1
   AST_OE_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> (dout_en == '0 && dout == '0)); // R6
endmodule

// File: rtl/dpram_dual_latsel.sv
module dpram_dual_latsel #(
   parameter int unsigned ADDR_W  = 9,
   parameter int unsigned LANES   = 8,
   parameter int unsigned LANE_W  = 9,
   parameter bit          PIPE_EN = 1'b1
) (
   input  logic                    clk_a,
   input  logic                    rst_a_n,
   input  logic                    a_ce0_n,
   input  logic                    a_ce1,
   input  logic                    a_rw,
   input  logic                    a_ads_n,
   input  logic [LANES-1:0]        a_be_n,
   input  logic [ADDR_W-1:0]       a_addr,
   input  logic [LANES*LANE_W-1:0] a_wdata,
   input  logic                    a_oe_n,
   input  logic                    a_pipe,
   output logic [LANES*LANE_W-1:0] a_rdata,
   output logic [LANES-1:0]        a_lane_oe,
   input  logic                    clk_b,
   input  logic                    rst_b_n,
   input  logic                    b_ce0_n,
   input  logic                    b_ce1,
   input  logic                    b_rw,
   input  logic                    b_ads_n,
   input  logic [LANES-1:0]        b_be_n,
   input  logic [ADDR_W-1:0]       b_addr,
   input  logic [LANES*LANE_W-1:0] b_wdata,
   input  logic                    b_oe_n,
   input  logic                    b_pipe,
   output logic [LANES*LANE_W-1:0] b_rdata,
   output logic [LANES-1:0]        b_lane_oe,
   input  logic                    sleep_req
);
   localparam int unsigned DATA_W = LANES * LANE_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
         $error("ADDR_W must lie in 1..12");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
         $error("LANES and LANE_W must be at least 1");
      end
   endgenerate

   logic              a_asleep,  b_asleep;
   logic [ADDR_W-1:0] a_eaddr,   b_eaddr;
   logic [LANES-1:0]  a_we,      b_we;
   logic              a_rfire,   b_rfire;
   logic [LANES-1:0]  a_rlanes,  b_rlanes;
   logic [DATA_W-1:0] a_rword,   b_rword;

   dpram_sleep_seq u_sleep_a (.clk(clk_a), .rst_n(rst_a_n), .sleep_req(sleep_req), .asleep(a_asleep));
   dpram_sleep_seq u_sleep_b (.clk(clk_b), .rst_n(rst_b_n), .sleep_req(sleep_req), .asleep(b_asleep));

   dpram_port_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctl_a (
      .clk(clk_a), .rst_n(rst_a_n), .ce0_n(a_ce0_n), .ce1(a_ce1), .rw(a_rw),
      .ads_n(a_ads_n), .be_n(a_be_n), .addr(a_addr), .asleep(a_asleep),
      .eff_addr(a_eaddr), .we_lanes(a_we), .rd_fire(a_rfire), .rd_lanes(a_rlanes));

   dpram_port_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctl_b (
      .clk(clk_b), .rst_n(rst_b_n), .ce0_n(b_ce0_n), .ce1(b_ce1), .rw(b_rw),
      .ads_n(b_ads_n), .be_n(b_be_n), .addr(b_addr), .asleep(b_asleep),
      .eff_addr(b_eaddr), .we_lanes(b_we), .rd_fire(b_rfire), .rd_lanes(b_rlanes));

   dpram_xor_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
      .clk_a(clk_a), .a_addr(a_eaddr), .a_we(a_we), .a_wdata(a_wdata), .a_re(a_rfire), .a_rword(a_rword),
      .clk_b(clk_b), .b_addr(b_eaddr), .b_we(b_we), .b_wdata(b_wdata), .b_re(b_rfire), .b_rword(b_rword));

   dpram_out_stage #(.LANES(LANES), .LANE_W(LANE_W), .PIPE_EN(PIPE_EN)) u_out_a (
      .clk(clk_a), .rst_n(rst_a_n), .pipe_mode(a_pipe), .rd_fire(a_rfire), .rd_lanes(a_rlanes),
      .rd_word(a_rword), .asleep(a_asleep), .oe_n(a_oe_n), .dout(a_rdata), .dout_en(a_lane_oe));

   dpram_out_stage #(.LANES(LANES), .LANE_W(LANE_W), .PIPE_EN(PIPE_EN)) u_out_b (
      .clk(clk_b), .rst_n(rst_b_n), .pipe_mode(b_pipe), .rd_fire(b_rfire), .rd_lanes(b_rlanes),
      .rd_word(b_rword), .asleep(b_asleep), .oe_n(b_oe_n), .dout(b_rdata), .dout_en(b_lane_oe));
endmodule

// File: tb/dpram_dual_latsel_tb.sv
module dpram_dual_latsel_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 6;
   localparam int NL = 8;
   localparam int LW = 9;
   localparam int DW = NL * LW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic a_ce0_n, a_ce1, a_rw, a_ads_n, a_oe_n, a_pipe;
   logic b_ce0_n, b_ce1, b_rw, b_ads_n, b_oe_n, b_pipe;
   logic [NL-1:0] a_be_n, b_be_n, a_lane_oe, b_lane_oe;
   logic [AW-1:0] a_addr, b_addr;
   logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
   logic sleep_req;

   int unsigned checks = 0;
   int unsigned errors = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dpram_dual_latsel #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW), .PIPE_EN(1'b1)) dut_i (
      .clk_a(clk), .rst_a_n(rst_n), .a_ce0_n(a_ce0_n), .a_ce1(a_ce1), .a_rw(a_rw),
      .a_ads_n(a_ads_n), .a_be_n(a_be_n), .a_addr(a_addr), .a_wdata(a_wdata),
      .a_oe_n(a_oe_n), .a_pipe(a_pipe), .a_rdata(a_rdata), .a_lane_oe(a_lane_oe),
      .clk_b(clk), .rst_b_n(rst_n), .b_ce0_n(b_ce0_n), .b_ce1(b_ce1), .b_rw(b_rw),
      .b_ads_n(b_ads_n), .b_be_n(b_be_n), .b_addr(b_addr), .b_wdata(b_wdata),
      .b_oe_n(b_oe_n), .b_pipe(b_pipe), .b_rdata(b_rdata), .b_lane_oe(b_lane_oe),
      .sleep_req(sleep_req));

   localparam logic [DW-1:0] D1 = {8'hA5, 64'h0123_4567_89AB_CDEF};
   localparam logic [DW-1:0] D2 = {8'h3C, 64'hFEDC_BA98_7654_3210};
   localparam logic [DW-1:0] D3 = {8'h11, 64'h1111_2222_3333_4444};
   localparam logic [DW-1:0] D4 = {8'h99, 64'h5555_6666_7777_8888};
   localparam logic [DW-1:0] D5 = {8'h0F, 64'hDEAD_BEEF_0000_1234};
   localparam logic [DW-1:0] D6 = {8'hF0, 64'hCAFE_F00D_4321_8765};
   localparam logic [DW-1:0] D7 = {8'h5A, 64'h0F0F_0F0F_F0F0_F0F0};
   localparam logic [DW-1:0] D8 = {8'h77, 64'h1357_9BDF_2468_ACE0};
   localparam logic [DW-1:0] LOW4 = {36'h0, {36{1'b1}}};
   localparam logic [DW-1:0] D12 = (D2 & LOW4) | (D1 & ~LOW4);

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_a(input logic ce0n, input logic ce1v, input logic rwv, input logic adsn,
                        input logic [NL-1:0] ben, input logic [AW-1:0] ad, input logic [DW-1:0] wd);
      a_ce0_n = ce0n; a_ce1 = ce1v; a_rw = rwv; a_ads_n = adsn;
      a_be_n = ben; a_addr = ad; a_wdata = wd;
   endtask

   task automatic set_b(input logic ce0n, input logic ce1v, input logic rwv, input logic adsn,
                        input logic [NL-1:0] ben, input logic [AW-1:0] ad, input logic [DW-1:0] wd);
      b_ce0_n = ce0n; b_ce1 = ce1v; b_rw = rwv; b_ads_n = adsn;
      b_be_n = ben; b_addr = ad; b_wdata = wd;
   endtask

   task automatic idle_a(); set_a(1'b1, 1'b0, 1'b1, 1'b1, '1, '0, '0); endtask
   task automatic idle_b(); set_b(1'b1, 1'b0, 1'b1, 1'b1, '1, '0, '0); endtask

   task automatic write_a(input logic [AW-1:0] ad, input logic [DW-1:0] wd, input logic [NL-1:0] ben);
      set_a(1'b0, 1'b1, 1'b0, 1'b0, ben, ad, wd);
      tick();
      idle_a();
   endtask

   task automatic test_reset();
      chk("R11 port A lanes after reset", DW'(a_lane_oe), '0);
      chk("R11 port B lanes after reset", DW'(b_lane_oe), '0);
   endtask

   task automatic test_flow_and_lane_write();
      write_a(6'd5, D1, 8'h00);
      set_a(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 6'd5, '0);
      #1 chk("R1 nothing before capture edge", DW'(a_lane_oe), '0);
      tick();
      chk("R1 flow read lanes", DW'(a_lane_oe), DW'(8'hFF));
      chk("R1 flow read data", a_rdata, D1);
      idle_a();
      write_a(6'd5, D2, 8'hF0);
      set_a(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 6'd5, '0);
      tick();
      chk("R3 only enabled lanes written", a_rdata, D12);
      idle_a();
      tick();
   endtask

   task automatic test_pipe();
      set_b(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 6'd5, '0);
      tick();
      chk("R2 pipelined not yet after first edge", DW'(b_lane_oe), '0);
      idle_b();
      tick();
      chk("R2 pipelined lanes after second edge", DW'(b_lane_oe), DW'(8'hFF));
      chk("R2 pipelined data after second edge", b_rdata, D12);
      tick();
   endtask

   task automatic test_byte_read();
      set_a(1'b0, 1'b1, 1'b1, 1'b0, 8'h04, 6'd5, '0);
      tick();
      chk("R5 disabled lane enable", DW'(a_lane_oe), DW'(8'hFB));
      chk("R5 disabled lane data", a_rdata, D12 & ~({{(DW-LW){1'b0}}, {LW{1'b1}}} << (2*LW)));
      idle_a();
      tick();
   endtask

   task automatic test_deselect_and_oe();
      set_a(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 6'd5, '0);
      tick();
      a_ce1 = 1'b0;
      #1 chk("R4 deselect waits for edge", DW'(a_lane_oe), DW'(8'hFF));
      tick();
      chk("R4 deselect after edge", DW'(a_lane_oe), '0);
      set_a(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 6'd5, D8);
      tick();
      set_a(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 6'd5, '0);
      tick();
      chk("R4 deselected write dropped", a_rdata, D12);
      a_oe_n = 1'b1;
      #1 chk("R6 oe high blanks at once", DW'(a_lane_oe), '0);
      a_oe_n = 1'b0;
      #1 chk("R6 oe low restores at once", DW'(a_lane_oe), DW'(8'hFF));
      idle_a();
      tick();
   endtask

   task automatic test_ads();
      write_a(6'd7, D3, 8'h00);
      write_a(6'd9, D4, 8'h00);
      set_a(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 6'd7, '0);
      tick();
      chk("R7 strobe low loads address", a_rdata, D3);
      set_a(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 6'd9, '0);
      tick();
      chk("R7 strobe high keeps address", a_rdata, D3);
      set_a(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 6'd9, '0);
      tick();
      chk("R7 strobe low reloads", a_rdata, D4);
      idle_a();
      tick();
   endtask

   task automatic test_collide();
      write_a(6'd12, D5, 8'h00);
      set_a(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 6'd12, D6);
      set_b(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 6'd12, D7);
      tick();
      idle_b();
      set_a(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 6'd12, '0);
      tick();
      chk("R8 port B wins same-address write", a_rdata, D7);
      set_a(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 6'd12, D8);
      set_b(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 6'd12, '0);
      tick();
      idle_b();
      set_a(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 6'd12, '0);
      tick();
      chk("R8 read beside write returns old", b_rdata, D7);
      chk("R8 later read sees new word", a_rdata, D8);
      idle_a();
      tick();
   endtask

   task automatic test_sleep();
      set_a(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 6'd5, '0);
      sleep_req = 1'b1;
      tick();
      chk("R9 still awake after one edge", DW'(a_lane_oe), DW'(8'hFF));
      tick();
      chk("R9 asleep after two edges", DW'(a_lane_oe), '0);
      set_b(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 6'd5, D8);
      tick();
      idle_b();
      tick();
      chk("R9 no drive while asleep", DW'(a_lane_oe), '0);
      sleep_req = 1'b0;
      tick();
      chk("R10 asleep one edge after release", DW'(a_lane_oe), '0);
      tick();
      chk("R10 asleep two edges after release", DW'(a_lane_oe), '0);
      tick();
      chk("R10 third edge still ignores read", DW'(a_lane_oe), '0);
      tick();
      chk("R10 resumed lanes", DW'(a_lane_oe), DW'(8'hFF));
      chk("R9 contents kept, sleep write dropped", a_rdata, D12);
      idle_a();
      tick();
   endtask

   initial begin
      idle_a(); idle_b();
      a_oe_n = 1'b0; b_oe_n = 1'b0;
      a_pipe = 1'b0; b_pipe = 1'b1;
      sleep_req = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      test_reset();
      test_flow_and_lane_write();
      test_pipe();
      test_byte_read();
      test_deselect_and_oe();
      test_ads();
      test_collide();
      test_sleep();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule